// File: doc/BRIEF.md
# Dual-CPU Bus Bridge Control Decoder

This block sits on the main processor's address bus in a console with two processors. It sees nearly the whole address bus but only one bit of the data bus, so each register it owns is a single bit wide. It does the first-level address decode for the main side. From that decode it drives three things: the reset line of the secondary (sound) processor, that processor's bus-request line, and an active-low select for a separate I/O chip. The I/O chip answers accesses in the I/O region, which includes the console version register.

The block also holds the bank register for the secondary processor. This register chooses which 32 KB window of the main address space the secondary processor can reach. Because only one data bit enters the block, the secondary processor builds the bank value up one bit per write to a fixed address. Each write shifts the new bit in at the top, and the oldest bit drops off the bottom. After nine writes the register holds a complete value.

Both processor sides use a simple strobe: an access is valid during every clock cycle in which its strobe is high. The write-enable and the single data bit are sampled at the same edge.

Top module: `bridge_ctl_dec`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes its reset state after that edge: `sub_rst_n`=0 (secondary processor held in reset), `sub_busreq`=0, `bank_q`=0, and `io_sel_n`=1 while no strobe is active.
- R2: A main-side write (`m_stb`=1, `m_we`=1) to byte address 0xA11200 or 0xA11201 loads `m_wbit` into the reset control. After that edge, `sub_rst_n` equals the written bit (1 releases reset, 0 holds it).
- R3: A main-side write to byte address 0xA11100 or 0xA11101 loads `m_wbit` into the bus-request bit. After that edge, `sub_busreq` equals the written bit (1 requests the bus).
- R4: During a main-side read (`m_stb`=1, `m_we`=0) of 0xA11100 or 0xA11101, `m_rbit` equals `sub_grant` in the same cycle. During any other cycle, `m_rbit` is 0.
- R5: A secondary-side write (`s_stb`=1, `s_we`=1) to address 0x6000 shifts `s_wbit` into bit 8 of `bank_q`. Bits 8..1 move down to 7..0, and the old bit 0 is discarded.
- R6: Nine consecutive bank writes with bits v[0], v[1], ..., v[8] leave `bank_q` = v. In every cycle, `win_base` equals `bank_q` shifted left by 15 bits (24 bits wide).
- R7: `io_sel_n` is 0 in exactly those cycles where `m_stb`=1 and `m_addr` lies in 0xA10000..0xA1001F, for reads and for writes alike. At 0xA10020 or 0xA0FFFF it stays 1.
- R8: Writes to any other address have no effect on `sub_rst_n`, `sub_busreq` or `bank_q`. This includes main-side writes to 0xA11202, main-side reads of the control addresses, secondary-side writes to 0x6001 and secondary-side reads of 0x6000.
- R9: `io_sel_n` is 1 whenever `m_stb` is 0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Synchronous reset, active low |
| m_addr | input | 24 | Main-side byte address |
| m_stb | input | 1 | Main-side access valid |
| m_we | input | 1 | Main-side write (1) or read (0) |
| m_wbit | input | 1 | The single main-side data bit for writes |
| m_rbit | output | 1 | The single main-side data bit for reads |
| s_addr | input | 16 | Secondary-side address |
| s_stb | input | 1 | Secondary-side access valid |
| s_we | input | 1 | Secondary-side write (1) or read (0) |
| s_wbit | input | 1 | The single secondary-side data bit for writes |
| sub_grant | input | 1 | Bus granted by the secondary processor |
| sub_rst_n | output | 1 | Secondary processor reset, active low |
| sub_busreq | output | 1 | Bus request to the secondary processor, active high |
| bank_q | output | 9 | Current bank register value |
| win_base | output | 24 | Main-side base address of the selected 32 KB window |
| io_sel_n | output | 1 | I/O-chip select, active low |

## Verification
The bench builds the block with its default parameters: a 24-bit main address, a 9-bit bank register, a 15-bit window shift and a 5-bit I/O span. With these values a full bank load takes nine writes, so the bench can push in a complete pattern and then one extra bit to watch the oldest bit fall off. The 32-byte I/O span puts the select boundary at 0xA1001F/0xA10020, which the bench probes on both sides. The bench also targets the two-byte register aliases and the addresses next to them, which shows that decode covers exactly one address pair per register.

// File: rtl/bridge_pkg.sv
// Package: shared decode result type for the bus bridge control decoder.
// Assumes one-bit-wide registers; each flag is a qualified access hit.
package bridge_pkg;

    typedef struct packed {
        logic rst_wr;   // write hit on the reset control address pair
        logic breq_wr;  // write hit on the bus-request address pair
        logic breq_rd;  // read hit on the bus-request address pair
        logic io_hit;   // any strobed access inside the I/O window
    } main_dec_t;

endpackage

// File: rtl/main_decode.sv
// Module: main_decode
// Primary address decode for the main-side bus. Each one-bit register owns
// an aligned address pair (both byte lanes); the I/O window is a power-of-two
// span. Assumes m_stb qualifies the address, so nothing is decoded without it.
module main_decode
    import bridge_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] RST_BASE  = 24'hA11200,
    parameter logic [23:0] BREQ_BASE = 24'hA11100,
    parameter logic [23:0] IO_BASE   = 24'hA10000,
    parameter int          IO_LG2    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              stb,
    input  logic              we,
    output main_dec_t         dec
);
    localparam logic [ADDR_W-1:0] PAIR_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] IO_MASK   = ADDR_W'((1 << IO_LG2) - 1);
    localparam logic [ADDR_W-1:0] RST_KEY   = ADDR_W'(RST_BASE)  | PAIR_MASK;
    localparam logic [ADDR_W-1:0] BREQ_KEY  = ADDR_W'(BREQ_BASE) | PAIR_MASK;
    localparam logic [ADDR_W-1:0] IO_KEY    = ADDR_W'(IO_BASE)   | IO_MASK;

    logic rst_pair, breq_pair, io_win;

    // Address matches, ignoring the bits inside each decoded span
    always_comb begin
        rst_pair  = (addr | PAIR_MASK) == RST_KEY;
        breq_pair = (addr | PAIR_MASK) == BREQ_KEY;
        io_win    = (addr | IO_MASK)   == IO_KEY;
    end

    // Qualify the matches with strobe and direction
    always_comb begin
        dec.rst_wr  = stb & we  & rst_pair;
        dec.breq_wr = stb & we  & breq_pair;
        dec.breq_rd = stb & ~we & breq_pair;
        dec.io_hit  = stb & io_win;
    end
endmodule

// File: rtl/bit_reg.sv
// Module: bit_reg
// One-bit control register with a load enable and a reset value.
// Assumes synchronous active-low reset.
module bit_reg #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // Hold the bit; take d on load
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RESET_VAL;
        else if (load) q <= d;
    end
endmodule

// File: rtl/bank_shifter.sv
// Module: bank_shifter
// Bank register filled serially from a single data bit: each shift puts din
// at the MSB and drops the LSB. Assumes synchronous active-low reset to zero.
module bank_shifter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift the new bit in at the top
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {din, q[W-1:1]};
    end
endmodule

// File: rtl/bridge_ctl_dec.sv
// Module: bridge_ctl_dec (top)
// Bus bridge control decoder: main-side address decode, the secondary
// processor's reset and bus-request bits, its serially loaded bank register,
// and the active-low I/O-chip select. Only one data bit reaches this block.
// Assumes one clock domain and strobes that qualify each access per cycle.
module bridge_ctl_dec
    import bridge_pkg::*;
#(
    parameter int           ADDR_W    = 24,
    parameter int           S_ADDR_W  = 16,
    parameter int           BANK_W    = 9,
    parameter int           WIN_SHIFT = 15,
    parameter int           IO_LG2    = 5,
    parameter logic [15:0]  BANK_ADDR = 16'h6000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           m_addr,
    input  logic                        m_stb,
    input  logic                        m_we,
    input  logic                        m_wbit,
    output logic                        m_rbit,
    input  logic [S_ADDR_W-1:0]         s_addr,
    input  logic                        s_stb,
    input  logic                        s_we,
    input  logic                        s_wbit,
    input  logic                        sub_grant,
    output logic                        sub_rst_n,
    output logic                        sub_busreq,
    output logic [BANK_W-1:0]           bank_q,
    output logic [BANK_W+WIN_SHIFT-1:0] win_base,
    output logic                        io_sel_n
);
    localparam logic [S_ADDR_W-1:0] BANK_KEY = S_ADDR_W'(BANK_ADDR);

    main_dec_t dec;
    logic      bank_wr;

    main_decode #(
        .ADDR_W (ADDR_W),
        .IO_LG2 (IO_LG2)
    ) u_dec (
        .addr (m_addr),
        .stb  (m_stb),
        .we   (m_we),
        .dec  (dec)
    );

    // Reset control resets to 0 so the secondary processor starts held
    bit_reg #(.RESET_VAL(1'b0)) u_rst_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dec.rst_wr),
        .d     (m_wbit),
        .q     (sub_rst_n)
    );

    bit_reg #(.RESET_VAL(1'b0)) u_breq_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dec.breq_wr),
        .d     (m_wbit),
        .q     (sub_busreq)
    );

    // Secondary-side bank write decode
    always_comb bank_wr = s_stb & s_we & (s_addr == BANK_KEY);

    bank_shifter #(.W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (bank_wr),
        .din   (s_wbit),
        .q     (bank_q)
    );

    // Outputs: window base, grant readback, I/O select
    always_comb begin
        win_base = {bank_q, {WIN_SHIFT{1'b0}}};
        m_rbit   = dec.breq_rd & sub_grant;
        io_sel_n = ~dec.io_hit;
    end

    // R2: a reset-control write shows up on the output one edge later
    a_r2_rst_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && m_we && ((m_addr | ADDR_W'(1)) == ADDR_W'(24'hA11201)))
        |=> (sub_rst_n == $past(m_wbit)));

    // R3: a bus-request write shows up on the output one edge later
    a_r3_breq_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && m_we && ((m_addr | ADDR_W'(1)) == ADDR_W'(24'hA11101)))
        |=> (sub_busreq == $past(m_wbit)));

    // R5: a bank write moves the old upper bits down by one place
    a_r5_bank_shift: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> (bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1])));

    // R8: with no bank write the bank register does not move
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_stb && s_we && (s_addr == BANK_KEY)) |=> $stable(bank_q));

    // R9: no select without a main-side strobe
    a_r9_io_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !m_stb |-> io_sel_n);

    // R4: readback only during a strobed read
    a_r4_rbit_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_stb || m_we) |-> !m_rbit);
endmodule

// File: tb/bridge_ctl_dec_tb_top.sv
`timescale 1ns/1ps
module bridge_ctl_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] m_addr = '0;
    logic        m_stb = 1'b0, m_we = 1'b0, m_wbit = 1'b0;
    logic        m_rbit;
    logic [15:0] s_addr = '0;
    logic        s_stb = 1'b0, s_we = 1'b0, s_wbit = 1'b0;
    logic        sub_grant = 1'b0;
    logic        sub_rst_n, sub_busreq, io_sel_n;
    logic [8:0]  bank_q;
    logic [23:0] win_base;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    bridge_ctl_dec dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_addr(m_addr), .m_stb(m_stb), .m_we(m_we), .m_wbit(m_wbit), .m_rbit(m_rbit),
        .s_addr(s_addr), .s_stb(s_stb), .s_we(s_we), .s_wbit(s_wbit),
        .sub_grant(sub_grant), .sub_rst_n(sub_rst_n), .sub_busreq(sub_busreq),
        .bank_q(bank_q), .win_base(win_base), .io_sel_n(io_sel_n)
    );

    typedef struct packed {
        logic        sec;    // 1: secondary side, 0: main side
        logic        we;
        logic [23:0] addr;
        logic        wbit;
        logic        x_rst;  // expected sub_rst_n afterwards
        logic        x_breq; // expected sub_busreq afterwards
        logic [8:0]  x_bank; // expected bank_q afterwards
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 24'hA11200, 1'b1, 1'b1, 1'b0, 9'h000}, // R2 release reset
        '{1'b0, 1'b1, 24'hA11101, 1'b1, 1'b1, 1'b1, 9'h000}, // R3 request bus, odd byte
        '{1'b0, 1'b1, 24'hA11202, 1'b0, 1'b1, 1'b1, 9'h000}, // R8 neighbour address
        '{1'b0, 1'b0, 24'hA11200, 1'b0, 1'b1, 1'b1, 9'h000}, // R8 read, no write
        '{1'b0, 1'b1, 24'hA11201, 1'b0, 1'b0, 1'b1, 9'h000}, // R2 hold reset, odd byte
        '{1'b1, 1'b1, 24'h006000, 1'b1, 1'b0, 1'b1, 9'h100}, // R5 first bit
        '{1'b1, 1'b1, 24'h006000, 1'b1, 1'b0, 1'b1, 9'h180}, // R5 second bit
        '{1'b1, 1'b1, 24'h006001, 1'b0, 1'b0, 1'b1, 9'h180}, // R8 wrong bank address
        '{1'b1, 1'b1, 24'h006000, 1'b0, 1'b0, 1'b1, 9'h0C0}, // R5 zero shifted in
        '{1'b0, 1'b1, 24'hA11100, 1'b0, 1'b0, 1'b0, 9'h0C0}, // R3 release bus
        '{1'b1, 1'b0, 24'h006000, 1'b1, 1'b0, 1'b0, 9'h0C0}  // R8 secondary read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access: drive on a falling edge, hold through one rising edge
    task automatic access(input logic sec, input logic we, input logic [23:0] addr, input logic b);
        @(negedge clk);
        if (sec) begin
            s_stb = 1'b1; s_we = we; s_addr = addr[15:0]; s_wbit = b;
        end else begin
            m_stb = 1'b1; m_we = we; m_addr = addr; m_wbit = b;
        end
        @(negedge clk);
        m_stb = 1'b0; m_we = 1'b0; m_wbit = 1'b0;
        s_stb = 1'b0; s_we = 1'b0; s_wbit = 1'b0;
    endtask

    // Combinational probe on the main side, sampled mid-cycle
    task automatic probe(input logic we, input logic [23:0] addr, output logic sel, output logic rb);
        @(negedge clk);
        m_stb = 1'b1; m_we = we; m_addr = addr;
        #1;
        sel = io_sel_n; rb = m_rbit;
        m_stb = 1'b0; m_we = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic sel, rb;
        logic [8:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sub_rst_n", sub_rst_n, 0);
        check("R1 sub_busreq", sub_busreq, 0);
        check("R1 bank_q", bank_q, 0);
        check("R1 io_sel_n", io_sel_n, 1);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].sec, VECS[i].we, VECS[i].addr, VECS[i].wbit);
            check($sformatf("R2 vec%0d sub_rst_n", i), sub_rst_n, VECS[i].x_rst);
            check($sformatf("R3 vec%0d sub_busreq", i), sub_busreq, VECS[i].x_breq);
            check($sformatf("R5 R8 vec%0d bank_q", i), bank_q, VECS[i].x_bank);
        end

        // R6 full nine-bit load, LSB first, then one more bit drops the oldest
        v = 9'h15A;
        for (int k = 0; k < 9; k++) access(1'b1, 1'b1, 24'h006000, v[k]);
        check("R6 bank full load", bank_q, 9'h15A);
        check("R6 win_base", win_base, 24'hAD0000);
        access(1'b1, 1'b1, 24'h006000, 1'b0);
        check("R5 oldest bit dropped", bank_q, 9'h0AD);
        check("R6 win_base after shift", win_base, 24'h568000);

        // R7 / R9 I/O select boundaries
        probe(1'b0, 24'hA10000, sel, rb); check("R7 io base read", sel, 0);
        probe(1'b1, 24'hA1001F, sel, rb); check("R7 io top write", sel, 0);
        probe(1'b0, 24'hA10020, sel, rb); check("R7 io above", sel, 1);
        probe(1'b0, 24'hA0FFFF, sel, rb); check("R7 io below", sel, 1);
        @(negedge clk); m_addr = 24'hA10001; #1;
        check("R9 io no strobe", io_sel_n, 1);

        // R4 grant readback
        sub_grant = 1'b1;
        probe(1'b0, 24'hA11100, sel, rb); check("R4 grant=1 read", rb, 1);
        probe(1'b0, 24'hA11101, sel, rb); check("R4 grant=1 odd byte", rb, 1);
        probe(1'b0, 24'hA11200, sel, rb); check("R4 other address reads 0", rb, 0);
        probe(1'b1, 24'hA11100, sel, rb); check("R4 write gives no readback", rb, 0);
        sub_grant = 1'b0;
        probe(1'b0, 24'hA11100, sel, rb); check("R4 grant=0 read", rb, 0);

        // R1 reset in mid-run after setting everything
        access(1'b0, 1'b1, 24'hA11200, 1'b1);
        access(1'b0, 1'b1, 24'hA11100, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid reset sub_rst_n", sub_rst_n, 0);
        check("R1 mid reset sub_busreq", sub_busreq, 0);
        check("R1 mid reset bank_q", bank_q, 0);

        summary();
    end
endmodule